// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This block is a 32-bit integer arithmetic and logic unit that produces a result and a set of six status flags. One shared adder handles the arithmetic operations: addition, addition with the stored carry, subtraction, subtraction with the stored borrow, two's-complement negation and compare. A bitwise stage handles AND, OR, XOR, NOT and test. The result path is combinational. The flags go into a register that loads on the clock edge when the caller raises a valid strobe.

The carry input for the chained forms comes from the stored carry flag, so multi-word additions and subtractions run as a series of strobed operations. A write-back enable tells the surrounding datapath whether the result should be stored. Compare and test change the flags only; NOT changes the result only. The combinational next-flag word is also exported, so a consumer can see the flags one cycle before the register loads them.

Top module: `alu_flagger`

## Requirements
- R1: The operation select `op` uses this encoding: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 negate, 5 AND, 6 OR, 7 XOR, 8 NOT, 9 compare, 10 test. Add-with-carry adds the stored carry flag. Subtract-with-borrow also subtracts the stored carry flag. Negate produces 0 minus `opa`.
- R2: The flag word has carry at bit 0, parity at bit 1, auxiliary at bit 2, zero at bit 3, sign at bit 4 and overflow at bit 5. For additions, carry is the carry out of bit 31. For subtractions and compare, carry is the borrow. For negate, carry is 1 unless the operand is zero.
- R3: Overflow is 1 exactly when the signed two's-complement result of an arithmetic operation cannot be held in 32 bits.
- R4: Auxiliary is the carry out of bit 3 for additions and the borrow out of bit 3 for subtractions, compare and negate.
- R5: Zero is 1 exactly when all 32 result bits are 0. Sign equals result bit 31.
- R6: Parity is 1 when bits 7:0 of the result hold an even number of ones. Bits 31:8 have no effect on it.
- R7: AND, OR and XOR write their result and clear carry, overflow and auxiliary.
- R8: Compare sets the flags exactly as subtract would for the same operands. It never asserts `wb_en`.
- R9: Test sets sign, zero and parity from `opa & opb`, clears carry, overflow and auxiliary, and never asserts `wb_en`.
- R10: NOT writes `~opa` and leaves all six flags unchanged.
- R11: After reset the flag register is all zeros. It loads only on a clock edge with `valid` high. `wb_en` is low whenever `valid` is low.
- R12: Select codes 11 to 15 never assert `wb_en` and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Operation strobe; loads the flag register |
| op | input | 4 | Operation select |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| result | output | 32 | Combinational result |
| wb_en | output | 1 | Result should be stored by the caller |
| flags_next | output | 6 | Combinational flag word for the current operation |
| flags_q | output | 6 | Registered flag word |

## Verification
On every cycle, the assertions check that the registered zero, sign and parity flags match the result of the preceding strobed operation. They also check that the logical operations leave carry and overflow cleared, that NOT and idle cycles keep the flag word stable, and that write-back never rises without the strobe. The arithmetic meaning of carry, borrow, auxiliary and signed overflow, and the chaining of the stored carry through add-with-carry and subtract-with-borrow, can only be shown by the bench's directed scenarios. Those scenarios compare against a separately written wide-integer model.

// File: rtl/alu_flagger.sv
module alu_flagger #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] result,
  output logic         wb_en,
  output logic [5:0]   flags_next,
  output logic [5:0]   flags_q
);

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADC  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SBB  = 4'd3;
  localparam logic [3:0] OP_NEG  = 4'd4;
  localparam logic [3:0] OP_AND  = 4'd5;
  localparam logic [3:0] OP_OR   = 4'd6;
  localparam logic [3:0] OP_XOR  = 4'd7;
  localparam logic [3:0] OP_NOT  = 4'd8;
  localparam logic [3:0] OP_CMP  = 4'd9;
  localparam logic [3:0] OP_TEST = 4'd10;

  localparam int FC = 0, FP = 1, FA = 2, FZ = 3, FS = 4, FO = 5;

  logic is_sub, is_arith, is_logic, uses_c, known, cin;
  logic [W-1:0] x, y, logic_res;
  logic [W:0]   sum;
  logic [4:0]   nib;
  logic         ovf;

  assign is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP) || (op == OP_NEG);
  assign is_arith = is_sub || (op == OP_ADD) || (op == OP_ADC);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_TEST);
  assign uses_c   = (op == OP_ADC) || (op == OP_SBB);
  assign known    = (op <= OP_TEST);

  assign x   = (op == OP_NEG) ? '0 : opa;
  assign y   = is_sub ? ~((op == OP_NEG) ? opa : opb) : opb;
  assign cin = is_sub ^ (uses_c & flags_q[FC]);

  assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign nib = {1'b0, x[3:0]} + {1'b0, y[3:0]} + {4'b0, cin};
  assign ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

  always_comb begin
    unique case (op)
      OP_AND, OP_TEST: logic_res = opa & opb;
      OP_OR:           logic_res = opa | opb;
      OP_XOR:          logic_res = opa ^ opb;
      OP_NOT:          logic_res = ~opa;
      default:         logic_res = '0;
    endcase
  end

  assign result = is_arith ? sum[W-1:0] : logic_res;
  assign wb_en  = valid && known && (op != OP_CMP) && (op != OP_TEST);

  always_comb begin
    flags_next = flags_q;
    if (is_arith || is_logic) begin
      flags_next[FZ] = (result == '0);
      flags_next[FS] = result[W-1];
      flags_next[FP] = ~^result[7:0];
      flags_next[FC] = is_arith & (sum[W] ^ is_sub);
      flags_next[FA] = is_arith & (nib[4] ^ is_sub);
      flags_next[FO] = is_arith & ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flags_q <= '0;
    else if (valid) flags_q <= flags_next;
  end

  AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(flags_q)); // R11
  AST_NO_WB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !wb_en); // R11
  AST_NOT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == OP_NOT) |=> $stable(flags_q)); // R10
  AST_LOGIC_CLEARS_CO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_logic) |=> (!flags_q[FC] && !flags_q[FO] && !flags_q[FA])); // R7
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (is_arith || is_logic)) |=> (flags_q[FZ] == ($past(result) == '0))); // R5
  AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (is_arith || is_logic)) |=> (flags_q[FS] == $past(result[W-1]))); // R5
  AST_PARITY_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (is_arith || is_logic)) |=> (flags_q[FP] == ~^$past(result[7:0]))); // R6
  AST_UNKNOWN_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !known) |=> (!$past(wb_en) && $stable(flags_q))); // R12

endmodule

// File: tb/test_alu_flagger.sv
module test_alu_flagger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] result;
  logic        wb_en;
  logic [5:0]  flags_next, flags_q;

  int checks = 0, fails = 0;
  logic [5:0] mflags = '0;

  always #5 clk = ~clk;

  alu_flagger i_alu_flagger (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .opa(opa), .opb(opb),
    .result(result), .wb_en(wb_en), .flags_next(flags_next), .flags_q(flags_q)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void ref_model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                                    input logic [5:0] fin, output logic [31:0] r,
                                    output logic wb, output logic [5:0] fo);
    logic [63:0] s;
    logic [31:0] p, q;
    longint sl;
    int c;
    fo = fin; r = '0; wb = (o <= 4'd10) && (o != 4'd9) && (o != 4'd10);
    case (o)
      4'd0, 4'd1: begin
        c = (o == 4'd1) ? int'(fin[0]) : 0;
        s = {32'b0, a} + {32'b0, b} + 64'(c);
        r = s[31:0];
        fo[0] = s[32];
        fo[2] = (int'(a[3:0]) + int'(b[3:0]) + c) > 15;
        sl = longint'($signed(a)) + longint'($signed(b)) + longint'(c);
        fo[5] = (sl > 64'sd2147483647) || (sl < -64'sd2147483648);
      end
      4'd2, 4'd3, 4'd4, 4'd9: begin
        c = (o == 4'd3) ? int'(fin[0]) : 0;
        p = (o == 4'd4) ? 32'd0 : a;
        q = (o == 4'd4) ? a : b;
        r = p - q - 32'(c);
        fo[0] = ({32'b0, q} + 64'(c)) > {32'b0, p};
        fo[2] = (int'(q[3:0]) + c) > int'(p[3:0]);
        sl = longint'($signed(p)) - longint'($signed(q)) - longint'(c);
        fo[5] = (sl > 64'sd2147483647) || (sl < -64'sd2147483648);
      end
      4'd5, 4'd10: r = a & b;
      4'd6: r = a | b;
      4'd7: r = a ^ b;
      4'd8: r = ~a;
      default: r = '0;
    endcase
    if (o inside {4'd5, 4'd6, 4'd7, 4'd10}) begin
      fo[0] = 1'b0; fo[2] = 1'b0; fo[5] = 1'b0;
    end
    if (o <= 4'd10 && o != 4'd8) begin
      fo[3] = (r == 32'd0);
      fo[4] = r[31];
      fo[1] = ~^r[7:0];
    end
  endfunction

  task automatic do_op(input string tag, input logic [3:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic v);
    logic [31:0] er;
    logic ewb;
    logic [5:0] ef;
    @(negedge clk);
    op = o; opa = a; opb = b; valid = v;
    ref_model(o, a, b, mflags, er, ewb, ef);
    #1;
    check({tag, " wb_en"}, 32'(wb_en), 32'(ewb && v));
    if (ewb) check({tag, " result"}, result, er);
    if (v) mflags = ef;
    @(posedge clk); #1;
    check({tag, " flags"}, 32'(flags_q), 32'(mflags));
    valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check("R11 reset flags", 32'(flags_q), 32'd0);
    check("R11 reset wb_en", 32'(wb_en), 32'd0);
  endtask

  task automatic t_add;
    do_op("R1 add small", 4'd0, 32'd1, 32'd1, 1'b1);
    do_op("R2 R4 R5 add wrap", 4'd0, 32'hFFFF_FFFF, 32'd1, 1'b1);
    do_op("R3 add overflow", 4'd0, 32'h7FFF_FFFF, 32'd1, 1'b1);
    do_op("R4 add aux", 4'd0, 32'h0000_000F, 32'h0000_0001, 1'b1);
    do_op("R2 setup carry", 4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1);
    do_op("R1 adc uses carry", 4'd1, 32'd10, 32'd20, 1'b1);
    do_op("R1 adc no carry", 4'd1, 32'd10, 32'd20, 1'b1);
  endtask

  task automatic t_sub;
    do_op("R2 sub borrow", 4'd2, 32'd5, 32'd7, 1'b1);
    do_op("R1 sbb uses borrow", 4'd3, 32'd100, 32'd1, 1'b1);
    do_op("R3 sub overflow", 4'd2, 32'h8000_0000, 32'd1, 1'b1);
    do_op("R4 sub aux", 4'd2, 32'h10, 32'h1, 1'b1);
    do_op("R5 sub zero", 4'd2, 32'h1234_5678, 32'h1234_5678, 1'b1);
  endtask

  task automatic t_neg;
    do_op("R2 neg zero", 4'd4, 32'd0, 32'd0, 1'b1);
    do_op("R2 neg five", 4'd4, 32'd5, 32'd0, 1'b1);
    do_op("R3 neg min", 4'd4, 32'h8000_0000, 32'd0, 1'b1);
  endtask

  task automatic t_parity;
    do_op("R6 even low byte", 4'd6, 32'hFF00_0003, 32'd0, 1'b1);
    do_op("R6 odd low byte", 4'd6, 32'h0000_0001, 32'd0, 1'b1);
    do_op("R6 upper ignored", 4'd6, 32'h7FFF_FF00, 32'd0, 1'b1);
  endtask

  task automatic t_logic;
    do_op("R7 setup flags", 4'd0, 32'h7FFF_FFFF, 32'h8000_000F, 1'b1);
    do_op("R7 and", 4'd5, 32'hF0F0_1234, 32'hFF00_FF0F, 1'b1);
    do_op("R3 setup ovf", 4'd0, 32'h7FFF_FFFF, 32'd1, 1'b1);
    do_op("R7 xor", 4'd7, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1);
    do_op("R7 or", 4'd6, 32'h8000_0000, 32'h0000_0001, 1'b1);
  endtask

  task automatic t_cmp_test;
    do_op("R8 cmp less", 4'd9, 32'd3, 32'd9, 1'b1);
    do_op("R8 cmp equal", 4'd9, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1);
    do_op("R2 setup carry", 4'd2, 32'd0, 32'd1, 1'b1);
    do_op("R9 test", 4'd10, 32'h8000_00F0, 32'h8000_0030, 1'b1);
    do_op("R9 test zero", 4'd10, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b1);
  endtask

  task automatic t_not;
    do_op("R10 setup", 4'd2, 32'd0, 32'd1, 1'b1);
    do_op("R10 not", 4'd8, 32'h0000_FFFF, 32'd0, 1'b1);
    do_op("R10 not zero", 4'd8, 32'hFFFF_FFFF, 32'd0, 1'b1);
  endtask

  task automatic t_idle_unknown;
    do_op("R11 idle", 4'd0, 32'hFFFF_FFFF, 32'd1, 1'b0);
    do_op("R11 idle cmp", 4'd9, 32'd0, 32'd1, 1'b0);
    do_op("R12 code 11", 4'd11, 32'd0, 32'd1, 1'b1);
    do_op("R12 code 15", 4'd15, 32'hFFFF_FFFF, 32'd1, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset;
        #22 rst_n = 1'b1;
        t_add;
        t_sub;
        t_neg;
        t_parity;
        t_logic;
        t_cmp_test;
        t_not;
        t_idle_unknown;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R11 watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule